// File: doc/BRIEF.md
# Dual-scan color panel timing generator

This block produces the frame, line and shift strobes for a 640x480 dual-scan color passive LCD panel. It also packs the panel data for that panel. The panel has an upper half and a lower half, and both are refreshed in the same line period. Each line period therefore serves upper row n and lower row n+240 together, so a full frame is 240 paired line periods plus the vertical blanking lines.

Horizontal timing is counted in pixel-clock enables. The display and blanking lengths are set in groups of eight enables. The vertical display length is programmed as a count of physical panel rows, and the block halves it because each line period covers two rows. An upstream source supplies four one-bit subpixels per half whenever the block requests them. The stream runs in R, G, B order per pixel and ignores pixel boundaries. The block reverses each group so that the earliest subpixel lands on the top bit of its nibble. It also toggles a drive-polarity signal once per frame and flags a horizontal display length that does not equal one full panel row of shifts.

A new period setting is taken at the next frame boundary, so a frame never mixes two geometries.

Top module: `dual_scan_lcd_timing`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears to 0, both counters return to the first line, and the four period inputs are captured as the active setting.
- R2: A line period lasts (hdisp_cfg+1)*8 + (hndp_cfg+1)*8 pixel enables. `fp_line` is high for exactly 8 pixel enables, starting at the first enable after the horizontal display span.
- R3: `fp_shift` is a one-clock pulse after every pixel enable that falls inside the horizontal display span of a vertical display line, and it is 0 everywhere else. A display line therefore gives (hdisp_cfg+1)*8 shifts.
- R4: A frame holds floor((vdisp_cfg+1)/2) display lines followed by vndp_cfg+1 blanking lines. `fp_line` pulses in every line, blanking lines included.
- R5: `fp_frame` is high for the whole last blanking line of each frame, and for no other line.
- R6: On each shift, `fp_dat[7:4]` carries `up_sub` reversed and `fp_dat[3:0]` carries `lo_sub` reversed. Bit 0 of each input is the earliest subpixel and appears on bit 7 or bit 3 respectively. `fp_dat[15:8]` stays 0.
- R7: `data_req` is high, combinationally, in exactly those cycles whose pixel enable produces a shift. `up_sub` and `lo_sub` are captured in that cycle.
- R8: `fp_mod` inverts once at each frame boundary and at no other time.
- R9: A change on any period input takes effect only at the next frame boundary.
- R10: `cfg_err` is 1 exactly when the active horizontal display span, (hdisp_cfg+1)*8, differs from 640*3/4 = 480 shifts.
- R11: `fp_line`, `fp_frame`, `fp_mod` and `fp_dat` change only on clock edges where `pix_en` is high, so their widths scale with the enable rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one shift slot per enable |
| vdisp_cfg | input | 10 | Vertical display rows minus one (physical rows) |
| vndp_cfg | input | 6 | Vertical blanking line periods minus one |
| hdisp_cfg | input | 7 | Horizontal display groups of 8 enables, minus one |
| hndp_cfg | input | 5 | Horizontal blanking groups of 8 enables, minus one |
| up_sub | input | 4 | Upper-half subpixel group, bit 0 earliest |
| lo_sub | input | 4 | Lower-half subpixel group, bit 0 earliest |
| data_req | output | 1 | Current cycle consumes one subpixel group per half |
| fp_frame | output | 1 | Frame marker, high during the last blanking line |
| fp_line | output | 1 | Line strobe, 8 enables wide in horizontal blanking |
| fp_shift | output | 1 | Shift strobe, one clock per data group |
| fp_mod | output | 1 | Drive-polarity toggle, inverts every frame |
| fp_dat | output | 16 | Packed panel data |
| cfg_err | output | 1 | Active display span does not equal 480 shifts |

## Verification
The bench checks a period change made in the middle of a frame. A generator that reloads at once would show the new 40-enable line period too early, instead of one frame later. It runs the pixel enable at one third rate. A design that counted clocks rather than enables would then give 8-clock line strobes and 496-clock lines, where 24 and 1488 are expected. It uses an odd vertical row count to expose a wrong halving. A scoreboard compares every packed byte, so a bit-order slip or a lane swap between the two halves shows up on the first shift.

// File: rtl/lcd_scan_pkg.sv
// Shared widths and the active period setting for the dual-scan timing block.
// Assumes groups of 8 pixel enables and 4-subpixel nibbles per panel half.
package lcd_scan_pkg;

    localparam int VD_W   = 10;  // vertical display rows field
    localparam int VN_W   = 6;   // vertical blanking lines field
    localparam int HD_W   = 7;   // horizontal display groups field
    localparam int HN_W   = 5;   // horizontal blanking groups field
    localparam int GRP    = 8;   // pixel enables per horizontal unit
    localparam int GRP_SH = $clog2(GRP);
    localparam int NIB    = 4;   // subpixels per half per shift
    localparam int DAT_W  = 16;  // panel data bus width
    localparam int HCNT_W = 12;  // holds (2^HD_W + 2^HN_W) * GRP
    localparam int VCNT_W = 10;  // holds 2^(VD_W-1) + 2^VN_W

    typedef struct packed {
        logic [VD_W-1:0] vrows;
        logic [VN_W-1:0] vblank;
        logic [HD_W-1:0] hgroups;
        logic [HN_W-1:0] hblank;
    } scan_cfg_t;

endpackage

// File: rtl/scan_hcount.sv
// Horizontal position counter, advanced by pixel enables.
// Assumes hdisp_len + GRP <= htot_len, which holds because the blanking
// span is always at least one group.
module scan_hcount
    import lcd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic [HCNT_W-1:0] hdisp_len,
    input  logic [HCNT_W-1:0] htot_len,
    output logic              h_act,
    output logic              line_win,
    output logic              line_last
);

    logic [HCNT_W-1:0] hpos;

    // Position within the line period, wraps after the last enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0;
        end else if (pix_en) begin
            hpos <= line_last ? '0 : hpos + HCNT_W'(1);
        end
    end

    // Decode display span, line-strobe window and last position.
    always_comb begin
        h_act     = hpos < hdisp_len;
        line_win  = (hpos >= hdisp_len) && (hpos < hdisp_len + HCNT_W'(GRP));
        line_last = hpos == htot_len - HCNT_W'(1);
    end

endmodule

// File: rtl/scan_vcount.sv
// Vertical line-period counter; one count covers an upper/lower row pair.
// Assumes vtot_len >= 1, which holds because blanking is at least one line.
module scan_vcount
    import lcd_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              line_last,
    input  logic [VCNT_W-1:0] vdisp_len,
    input  logic [VCNT_W-1:0] vtot_len,
    output logic              v_act,
    output logic              frame_line,
    output logic              frame_end
);

    logic [VCNT_W-1:0] vpos;
    logic              line_step;

    // A line step happens on the enable that ends a line period.
    assign line_step = pix_en && line_last;

    // Line-period index within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpos <= '0;
        end else if (line_step) begin
            vpos <= frame_line ? '0 : vpos + VCNT_W'(1);
        end
    end

    // Decode display lines, the frame-marker line and the frame wrap.
    always_comb begin
        v_act      = vpos < vdisp_len;
        frame_line = vpos == vtot_len - VCNT_W'(1);
        frame_end  = line_step && frame_line;
    end

endmodule

// File: rtl/subpixel_pack.sv
// Packs one subpixel group per panel half onto the data bus and issues the
// shift pulse. The earliest subpixel (input bit 0) goes to the top nibble bit.
// Data returns to zero on any enable that is not a shift.
module subpixel_pack
    import lcd_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             shift_now,
    input  logic [NIB-1:0]   up_sub,
    input  logic [NIB-1:0]   lo_sub,
    output logic             fp_shift,
    output logic [DAT_W-1:0] fp_dat
);

    localparam int PAD_W = DAT_W - 2 * NIB;

    logic [NIB-1:0] up_rev;
    logic [NIB-1:0] lo_rev;

    // Bit reversal so stream order runs from the nibble's top bit down.
    for (genvar i = 0; i < NIB; i++) begin : g_rev
        assign up_rev[NIB-1-i] = up_sub[i];
        assign lo_rev[NIB-1-i] = lo_sub[i];
    end

    // Shift strobe: one clock after each consuming enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_shift <= 1'b0;
        end else begin
            fp_shift <= shift_now;
        end
    end

    // Data register, updated only on pixel enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_dat <= '0;
        end else if (pix_en) begin
            fp_dat <= shift_now ? {{PAD_W{1'b0}}, up_rev, lo_rev} : '0;
        end
    end

endmodule

// File: rtl/dual_scan_lcd_timing.sv
// Top of the dual-scan color panel timing generator.
// Holds the active period setting (reloaded at frame wrap), derives period
// lengths, and drives the line, frame and polarity strobes.
// Assumes the source presents a subpixel group whenever data_req is high.
module dual_scan_lcd_timing
    import lcd_scan_pkg::*;
#(
    parameter int PANEL_W     = 640,
    parameter int SUB_PER_PIX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [VD_W-1:0]  vdisp_cfg,
    input  logic [VN_W-1:0]  vndp_cfg,
    input  logic [HD_W-1:0]  hdisp_cfg,
    input  logic [HN_W-1:0]  hndp_cfg,
    input  logic [NIB-1:0]   up_sub,
    input  logic [NIB-1:0]   lo_sub,
    output logic             data_req,
    output logic             fp_frame,
    output logic             fp_line,
    output logic             fp_shift,
    output logic             fp_mod,
    output logic [DAT_W-1:0] fp_dat,
    output logic             cfg_err
);

    localparam int SHIFTS_PER_LINE = PANEL_W * SUB_PER_PIX / NIB;

    scan_cfg_t         cfg_in;
    scan_cfg_t         cfg_act;
    logic [HCNT_W-1:0] hdisp_len;
    logic [HCNT_W-1:0] hblank_len;
    logic [HCNT_W-1:0] htot_len;
    logic [VCNT_W:0]   vrows_p1;
    logic [VCNT_W-1:0] vdisp_len;
    logic [VCNT_W-1:0] vtot_len;
    logic              h_act;
    logic              line_win;
    logic              line_last;
    logic              v_act;
    logic              frame_line;
    logic              frame_end;

    assign cfg_in = '{vrows: vdisp_cfg, vblank: vndp_cfg,
                      hgroups: hdisp_cfg, hblank: hndp_cfg};

    // Active setting: captured in reset and at each frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_act <= cfg_in;
        end else if (frame_end) begin
            cfg_act <= cfg_in;
        end
    end

    // Period lengths from the active setting.
    always_comb begin
        hdisp_len  = (HCNT_W'(cfg_act.hgroups) + HCNT_W'(1)) << GRP_SH;
        hblank_len = (HCNT_W'(cfg_act.hblank) + HCNT_W'(1)) << GRP_SH;
        htot_len   = hdisp_len + hblank_len;
        vrows_p1   = (VCNT_W + 1)'(cfg_act.vrows) + (VCNT_W + 1)'(1);
        vdisp_len  = vrows_p1[VCNT_W:1];
        vtot_len   = vdisp_len + VCNT_W'(cfg_act.vblank) + VCNT_W'(1);
        cfg_err    = hdisp_len != HCNT_W'(SHIFTS_PER_LINE);
    end

    scan_hcount u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .hdisp_len (hdisp_len),
        .htot_len  (htot_len),
        .h_act     (h_act),
        .line_win  (line_win),
        .line_last (line_last)
    );

    scan_vcount u_vcount (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .line_last  (line_last),
        .vdisp_len  (vdisp_len),
        .vtot_len   (vtot_len),
        .v_act      (v_act),
        .frame_line (frame_line),
        .frame_end  (frame_end)
    );

    // A group is consumed on enables inside the display area.
    assign data_req = pix_en && h_act && v_act;

    subpixel_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .shift_now (data_req),
        .up_sub    (up_sub),
        .lo_sub    (lo_sub),
        .fp_shift  (fp_shift),
        .fp_dat    (fp_dat)
    );

    // Line and frame strobes, registered on pixel enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_line  <= 1'b0;
            fp_frame <= 1'b0;
        end else if (pix_en) begin
            fp_line  <= line_win;
            fp_frame <= frame_line;
        end
    end

    // Polarity toggle at each frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_mod <= 1'b0;
        end else if (frame_end) begin
            fp_mod <= ~fp_mod;
        end
    end

endmodule

// File: rtl/dual_scan_lcd_timing_chk.sv
// Checker for the timing generator, attached by bind. Observes ports only.
module dual_scan_lcd_timing_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_en,
    input logic        data_req,
    input logic        fp_shift,
    input logic        fp_line,
    input logic        fp_frame,
    input logic        fp_mod,
    input logic [15:0] fp_dat
);

    AST_SHIFT_OUTSIDE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        fp_shift |-> !fp_line); // R3
    AST_SHIFT_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        fp_shift |-> !fp_frame); // R5
    AST_SHIFT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fp_shift |-> $past(data_req)); // R7
    AST_MOD_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fp_mod) |-> $past(fp_frame)); // R8
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_en) |-> $stable(fp_line) && $stable(fp_frame)); // R11
    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_en) |-> $stable(fp_dat)); // R11

endmodule

bind dual_scan_lcd_timing dual_scan_lcd_timing_chk u_chk (.*);

// File: tb/tb_dual_scan_lcd_timing.sv
`timescale 1ns/1ps
module tb_dual_scan_lcd_timing;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic [9:0]  vdisp_cfg = 10'd5;
    logic [5:0]  vndp_cfg = 6'd1;
    logic [6:0]  hdisp_cfg = 7'd59;
    logic [4:0]  hndp_cfg = 5'd1;
    logic [3:0]  up_sub = '0;
    logic [3:0]  lo_sub = '0;
    logic        data_req, fp_frame, fp_line, fp_shift, fp_mod, cfg_err;
    logic [15:0] fp_dat;

    always #10 clk = ~clk;

    dual_scan_lcd_timing dut (.*);

    int checks = 0, errors = 0, cyc = 0;
    int en_div = 1, ph = 0, gseq = 0;
    logic [15:0] expq[$];

    // Monitor measurements
    int line_rise = 0, line_period = 0, line_hi = 0, line_width = 0, line_count = 0;
    int shifts_line = 0, last_disp_shifts = 0, disp_lines = 0, last_disp_lines = 0;
    int lines_frame = 0, last_lines_frame = 0, shifts_frame = 0, last_shifts_frame = 0;
    int frame_rise = 0, frame_period = 0, frame_hi = 0, frame_width = 0, frame_count = 0;
    int data_bad = 0, data_ok = 0;
    logic prev_line = 0, prev_frame = 0, mod_prev = 0, mod_flipped = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] rev4(logic [3:0] x);
        return {x[0], x[1], x[2], x[3]};
    endfunction

    always @(posedge clk) cyc++;

    // Driver: pixel enable pacing and subpixel source; pushes expected bytes.
    task automatic drive_step();
        pix_en = rst_n && (ph == 0);
        ph = (ph + 1 >= en_div) ? 0 : ph + 1;
        #1;
        if (data_req) begin
            up_sub = 4'(gseq * 7 + 3);
            lo_sub = 4'(gseq * 11 + 5);
            expq.push_back({8'h00, rev4(up_sub), rev4(lo_sub)});
            gseq++;
        end
    endtask

    initial forever begin
        @(negedge clk);
        drive_step();
    end

    // Monitor: pops expected data on shifts and measures strobe timing.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (fp_shift) begin
                shifts_line++; shifts_frame++;
                if (expq.size() == 0) begin
                    data_bad++;
                    checks++; errors++;
                    $display("FAIL R7 shift without request actual 1 expected 0");
                end else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    if (fp_dat !== e) begin
                        data_bad++;
                        checks++; errors++;
                        $display("FAIL R6 fp_dat actual %h expected %h", fp_dat, e);
                    end else data_ok++;
                end
            end
            if (fp_line && !prev_line) begin
                line_period = cyc - line_rise; line_rise = cyc; line_count++;
                lines_frame++;
                if (shifts_line > 0) begin last_disp_shifts = shifts_line; disp_lines++; end
                shifts_line = 0;
            end
            if (fp_line) line_hi++;
            else if (prev_line) begin line_width = line_hi; line_hi = 0; end
            if (fp_frame && !prev_frame) begin
                frame_period = cyc - frame_rise; frame_rise = cyc;
                last_lines_frame = lines_frame; lines_frame = 0;
                last_shifts_frame = shifts_frame; shifts_frame = 0;
                last_disp_lines = disp_lines; disp_lines = 0;
                mod_flipped = (fp_mod != mod_prev); mod_prev = fp_mod;
                frame_count++;
            end
            if (fp_frame) frame_hi++;
            else if (prev_frame) begin frame_width = frame_hi; frame_hi = 0; end
            prev_line = fp_line; prev_frame = fp_frame;
        end
    end

    task automatic wait_frames(int n);
        int t;
        t = frame_count + n;
        wait (frame_count >= t);
        @(negedge clk);
    endtask

    task automatic wait_lines(int n);
        int t;
        t = line_count + n;
        wait (line_count >= t);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 fp_line", int'(fp_line), 0);
        chk("R1 fp_frame", int'(fp_frame), 0);
        chk("R1 fp_shift", int'(fp_shift), 0);
        chk("R1 fp_mod", int'(fp_mod), 0);
        chk("R1 fp_dat", int'(fp_dat), 0);
        chk("R10 cfg_err for 480-shift span", int'(cfg_err), 0);
        rst_n = 1'b1;

        // Full-rate enables, 480-shift lines, 3 display + 2 blanking lines
        wait_frames(3);
        chk("R2 line period", line_period, 496);
        chk("R2 fp_line width", line_width, 8);
        chk("R3 shifts per display line", last_disp_shifts, 480);
        chk("R3 shifts per frame", last_shifts_frame, 1440);
        chk("R4 lines per frame", last_lines_frame, 5);
        chk("R4 display lines per frame", last_disp_lines, 3);
        chk("R4 frame period", frame_period, 2480);
        chk("R5 fp_frame width", frame_width, 496);
        chk("R8 fp_mod inverted", int'(mod_flipped), 1);

        // One enable every third clock
        en_div = 3;
        wait_frames(3);
        chk("R11 line period at third rate", line_period, 1488);
        chk("R11 fp_line width at third rate", line_width, 24);
        chk("R11 fp_frame width at third rate", frame_width, 1488);
        chk("R3 shifts per display line at third rate", last_disp_shifts, 480);
        chk("R4 frame period at third rate", frame_period, 7440);
        chk("R8 fp_mod inverted at third rate", int'(mod_flipped), 1);

        // Change setting early in a frame: deferred to next frame
        en_div = 1;
        wait_frames(1);
        wait (fp_frame == 1'b0);
        @(negedge clk);
        hdisp_cfg = 7'd3; hndp_cfg = 5'd0; vndp_cfg = 6'd2; vdisp_cfg = 10'd6;
        wait_lines(2);
        chk("R9 old line period kept", line_period, 496);
        chk("R9 R10 cfg_err before wrap", int'(cfg_err), 0);
        wait_frames(1);
        wait (fp_frame == 1'b0);
        chk("R10 cfg_err for 32-shift span", int'(cfg_err), 1);
        wait_lines(2);
        chk("R9 new line period", line_period, 40);
        wait_frames(3);
        chk("R4 lines per frame with odd row count", last_lines_frame, 6);
        chk("R4 display lines from odd row count", last_disp_lines, 3);
        chk("R4 frame period new", frame_period, 240);
        chk("R3 shifts per display line new", last_disp_shifts, 32);
        chk("R5 fp_frame width new", frame_width, 40);
        chk("R6 packed data mismatches", data_bad, 0);
        chk("R6 packed data compared", int'(data_ok > 1000), 1);
        finish_run();
    end

endmodule